// File: doc/BRIEF.md
# Serial Byte-Addressed Memory Slave with Page Write and Region Lock

This block is the protocol engine of a small serial memory device. An external host talks to it over a four-wire synchronous serial link in clock-idle-low, sample-on-rising-edge mode. The link runs on slave-select, serial clock, data-in and data-out. Behind the engine sits a byte array of 512 entries, reached through a plain address/data/write-enable port. A separate protection guard sits beside it and reports, for any address the engine presents, whether that address is currently locked. The engine tells the guard which lock code is active.

All serial inputs are oversampled by the system clock. Each transaction begins with one command byte. Reads and writes then carry a two-byte address, of which only the low nine bits matter. A read streams bytes from consecutive addresses. A write gathers up to one page of sixteen bytes into a local buffer and commits it only when slave-select is released cleanly on a byte boundary. After a write or lock commit, the device stays busy for a fixed number of system clocks. During that time it answers only status polls, and those answer with all ones.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset the data-out enable is low, no array write is issued, the lock code is 0, and the write-enable latch is clear, so a write sent without a prior enable command changes nothing.
- R2: Data-in is captured on rising serial-clock edges, most significant bit first. Data-out changes only after falling edges. The data-out enable is high while slave-select is low and low while it is high.
- R3: Command codes: 0x06 sets the write-enable latch, 0x04 clears it, 0x05 reads status, 0x02 writes, 0x03 reads, and 0x01 followed by one code byte sets the lock. Any other code is ignored.
- R4: Read and write commands take a 16-bit address, high byte first. Bits 15..9 are ignored, so address 0xA123 selects location 0x123.
- R5: A read returns the byte at the address, then the following addresses one per byte. The address wraps from 0x1FF to 0x000 for as long as slave-select stays low.
- R6: Write data goes to the 16-byte page of the start address. The offset inside the page wraps from 15 to 0, and a later byte for the same location replaces the earlier one.
- R7: Buffered write data reaches the array only if slave-select rises with at least one complete data byte received and no partial byte pending. Otherwise the array is untouched and the write-enable latch keeps its value.
- R8: Set-enable and clear-enable act only if slave-select rises right after their 8 bits. Writes and lock commands act only while the latch is set. A completed write or lock commit clears the latch.
- R9: A status read shifts out {5'b0, lock code} repeatedly. While busy, data-out is driven high instead. The bit pointer keeps advancing during the busy time, so once busy ends the remaining bits come from the correct positions.
- R10: A commit holds the device busy for BUSY_CYCLES system clocks plus the page scan. While busy, every command except status read is ignored: reads return zero and writes change nothing.
- R11: A lock command stores the low 3 bits of its code byte on lock_code_o if slave-select rises right after 16 bits. During a write commit, bytes whose address the guard flags as locked are skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Slave select, active low |
| si_i | input | 1 | Serial data from the host |
| so_o | output | 1 | Serial data to the host |
| so_oe_o | output | 1 | Data-out enable (low means high impedance) |
| mem_addr_o | output | ADDR_W | Array address |
| mem_wdata_o | output | 8 | Array write data |
| mem_we_o | output | 1 | Array write strobe |
| mem_rdata_i | input | 8 | Array read data for mem_addr_o |
| lock_code_o | output | 3 | Active lock code for the protection guard |
| guard_block_i | input | 1 | Guard flags mem_addr_o as locked |

## Verification
A wrong byte or bit counter shows up at once in the next transfer. Read data comes out shifted, or a commit that should happen does not, and the read-back after the busy time exposes it. A stale write-enable latch or lock code is observable only indirectly: the next write with no enable command lands in the array, and a status poll returns a wrong code. The bench therefore follows every such event with a read-back or a poll. A busy counter that runs short or long is caught by status polls placed well inside and just after the expected busy window.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] CODE_WREN  = 8'h06;
  localparam logic [7:0] CODE_WRDI  = 8'h04;
  localparam logic [7:0] CODE_RDSR  = 8'h05;
  localparam logic [7:0] CODE_WRITE = 8'h02;
  localparam logic [7:0] CODE_READ  = 8'h03;
  localparam logic [7:0] CODE_LOCK  = 8'h01;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WREN,
    OP_WRDI,
    OP_RDSR,
    OP_WRITE,
    OP_READ,
    OP_LOCK
  } op_e;

  // Command decode; only status reads survive a busy period.
  function automatic op_e decode_op(input logic [7:0] code, input logic busy);
    op_e r;
    case (code)
      CODE_WREN:  r = OP_WREN;
      CODE_WRDI:  r = OP_WRDI;
      CODE_RDSR:  r = OP_RDSR;
      CODE_WRITE: r = OP_WRITE;
      CODE_READ:  r = OP_READ;
      CODE_LOCK:  r = OP_LOCK;
      default:    r = OP_NONE;
    endcase
    if (busy && (r != OP_RDSR)) r = OP_NONE;
    return r;
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic cs_end,
  output logic si_s
);

  logic [STAGES-1:0] sck_c, cs_c, si_c;
  logic [STAGES-1:0] sck_c_d, cs_c_d, si_c_d;
  logic sck_h, cs_h, sck_h_d, cs_h_d;

  assign sck_c_d = {sck_c[STAGES-2:0], sck_i};
  assign cs_c_d  = {cs_c[STAGES-2:0], cs_n_i};
  assign si_c_d  = {si_c[STAGES-2:0], si_i};
  assign sck_h_d = sck_c[STAGES-1];
  assign cs_h_d  = cs_c[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_c <= '0;
      cs_c  <= '1;
      si_c  <= '0;
      sck_h <= 1'b0;
      cs_h  <= 1'b1;
    end else begin
      sck_c <= sck_c_d;
      cs_c  <= cs_c_d;
      si_c  <= si_c_d;
      sck_h <= sck_h_d;
      cs_h  <= cs_h_d;
    end
  end

  assign sel      = !cs_c[STAGES-1];
  assign sck_rise = sck_c[STAGES-1] && !sck_h;
  assign sck_fall = !sck_c[STAGES-1] && sck_h;
  assign cs_end   = cs_c[STAGES-1] && !cs_h;
  assign si_s     = si_c[STAGES-1];

endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [W-1:0]     rd_data,
  output logic [DEPTH-1:0] valid
);

  logic [W-1:0]     slot [DEPTH];
  logic [DEPTH-1:0] valid_q, valid_d;

  always_comb begin
    valid_d = valid_q;
    if (clr) valid_d = '0;
    else if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_data;
  end

  assign rd_data = slot[rd_idx];
  assign valid   = valid_q;

endmodule

// File: rtl/spi_ee_commit.sv
module spi_ee_commit #(
  parameter int DEPTH       = 16,
  parameter int BUSY_CYCLES = 2000,
  localparam int IW         = $clog2(DEPTH),
  localparam int CW         = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             start_lock,
  input  logic [DEPTH-1:0] valid,
  input  logic             guard_block_i,
  output logic             busy,
  output logic [IW-1:0]    idx,
  output logic             mem_we,
  output logic             lock_we,
  output logic             done
);

  typedef enum logic [1:0] {C_IDLE, C_SCAN, C_WAIT} cst_e;

  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  cst_e          st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    mem_we  = 1'b0;
    lock_we = 1'b0;
    done    = 1'b0;
    case (st_q)
      C_IDLE: begin
        if (start_wr) begin
          st_d  = C_SCAN;
          idx_d = '0;
        end else if (start_lock) begin
          lock_we = 1'b1;
          st_d    = C_WAIT;
          cnt_d   = LOAD;
        end
      end
      C_SCAN: begin
        mem_we = valid[idx_q] && !guard_block_i;
        if (idx_q == LAST) begin
          st_d  = C_WAIT;
          cnt_d = LOAD;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      C_WAIT: begin
        if (cnt_q == '0) begin
          st_d = C_IDLE;
          done = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= C_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q != C_IDLE);
  assign idx  = idx_q;

endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [2:0]        lock_code_o,
  input  logic              guard_block_i
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam logic [2:0] BYTE_SAT = 3'd4;

  logic sck_rise, sck_fall, sel, cs_end, si_s;

  spi_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .cs_n_i(cs_n_i), .si_i(si_i),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel), .cs_end(cs_end), .si_s(si_s)
  );

  logic [2:0]        bit_q, bit_d;
  logic [2:0]        byte_q, byte_d;
  logic [7:0]        sh_q, sh_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wel_q, wel_d;
  logic [2:0]        lock_q, lock_d;
  logic [2:0]        pend_q, pend_d;
  logic              so_q, so_d;

  logic              buf_clr, buf_we, start_wr, start_lock;
  logic [7:0]        rx_byte, status, buf_rd;
  logic [PAGE_BYTES-1:0] buf_valid;
  logic              busy, c_we, lock_we, c_done;
  logic [OFF_W-1:0]  c_idx;

  spi_ee_pagebuf #(.DEPTH(PAGE_BYTES), .W(8)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_we),
    .wr_idx(addr_q[OFF_W-1:0]), .wr_data(rx_byte),
    .rd_idx(c_idx), .rd_data(buf_rd), .valid(buf_valid)
  );

  spi_ee_commit #(.DEPTH(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_lock(start_lock),
    .valid(buf_valid), .guard_block_i(guard_block_i), .busy(busy), .idx(c_idx),
    .mem_we(c_we), .lock_we(lock_we), .done(c_done)
  );

  assign rx_byte = {sh_q[6:0], si_s};
  assign status  = 8'(lock_q);

  always_comb begin
    bit_d      = bit_q;
    byte_d     = byte_q;
    sh_d       = sh_q;
    op_d       = op_q;
    addr_d     = addr_q;
    wel_d      = wel_q;
    lock_d     = lock_q;
    pend_d     = pend_q;
    so_d       = so_q;
    buf_clr    = 1'b0;
    buf_we     = 1'b0;
    start_wr   = 1'b0;
    start_lock = 1'b0;

    if (cs_end) begin
      // release of select: act only on clean byte boundaries
      if (bit_q == 3'd0) begin
        case (op_q)
          OP_WREN:  if (byte_q == 3'd1) wel_d = 1'b1;
          OP_WRDI:  if (byte_q == 3'd1) wel_d = 1'b0;
          OP_WRITE: if ((byte_q == BYTE_SAT) && wel_q && !busy) start_wr = 1'b1;
          OP_LOCK:  if ((byte_q == 3'd2) && wel_q && !busy) start_lock = 1'b1;
          default: ;
        endcase
      end
      bit_d  = '0;
      byte_d = '0;
      op_d   = OP_NONE;
      so_d   = 1'b0;
    end else if (!sel) begin
      bit_d  = '0;
      byte_d = '0;
      op_d   = OP_NONE;
      so_d   = 1'b0;
    end else begin
      if (sck_rise) begin
        sh_d  = rx_byte;
        bit_d = bit_q + 1'b1;
        if (bit_q == 3'd7) begin
          if (byte_q != BYTE_SAT) byte_d = byte_q + 1'b1;
          case (byte_q)
            3'd0: begin
              op_d = decode_op(rx_byte, busy);
              if (decode_op(rx_byte, busy) == OP_WRITE) buf_clr = 1'b1;
            end
            3'd1: begin
              if (op_q == OP_READ || op_q == OP_WRITE) addr_d = ADDR_W'({rx_byte, 8'h00});
              if (op_q == OP_LOCK) pend_d = rx_byte[2:0];
            end
            3'd2: begin
              if (op_q == OP_READ || op_q == OP_WRITE) addr_d = {addr_q[ADDR_W-1:8], rx_byte};
            end
            default: begin
              if (op_q == OP_READ) addr_d = addr_q + 1'b1;
              if (op_q == OP_WRITE) begin
                buf_we = 1'b1;
                addr_d = {addr_q[ADDR_W-1:OFF_W], addr_q[OFF_W-1:0] + 1'b1};
              end
            end
          endcase
        end
      end
      if (sck_fall) begin
        if (op_q == OP_READ && byte_q >= 3'd3) so_d = mem_rdata_i[~bit_q];
        else if (op_q == OP_RDSR && byte_q >= 3'd1) so_d = busy ? 1'b1 : status[~bit_q];
      end
    end

    if (lock_we) lock_d = pend_q;
    if (c_done)  wel_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      byte_q <= '0;
      sh_q   <= '0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      wel_q  <= 1'b0;
      lock_q <= '0;
      pend_q <= '0;
      so_q   <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      byte_q <= byte_d;
      sh_q   <= sh_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      wel_q  <= wel_d;
      lock_q <= lock_d;
      pend_q <= pend_d;
      so_q   <= so_d;
    end
  end

  logic [PG_W-1:0] page;
  assign page = addr_q[ADDR_W-1:OFF_W];

  assign mem_addr_o  = busy ? {page, c_idx} : addr_q;
  assign mem_wdata_o = buf_rd;
  assign mem_we_o    = c_we;
  assign so_o        = so_q;
  assign so_oe_o     = sel;
  assign lock_code_o = lock_q;

endmodule

// File: rtl/spi_ee_slave_chk.sv
module spi_ee_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wel,
  input logic       mem_we,
  input logic       guard_block,
  input logic [2:0] lock_code
);

  // R10: the array is written only inside a busy period
  a_r10_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R11: a locked address is never written
  a_r11_no_guarded_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !guard_block);

  // R8: a commit starts only with the enable latch set
  a_r8_busy_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel);

  // R8: the enable latch is clear once the busy period ends
  a_r8_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R11: the lock code moves only when a commit begins
  a_r11_lock_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_code) |-> busy);

endmodule

bind spi_ee_slave spi_ee_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel_q), .mem_we(mem_we_o),
  .guard_block(guard_block_i), .lock_code(lock_code_o)
);

// File: tb/tb_spi_ee_slave.sv
module tb_spi_ee_slave;

  localparam int BUSY = 1000;
  localparam int HALF = 4;

  logic clk, rst_n, sck, cs_n, si;
  logic so_o, so_oe_o, mem_we_o, guard_block_i;
  logic [8:0] mem_addr_o;
  logic [7:0] mem_wdata_o, mem_rdata_i;
  logic [2:0] lock_code_o;

  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];
  logic [7:0] wbytes [32];
  logic       exp_wel;
  logic [2:0] exp_lock;
  int n_chk, n_fail;
  bit finished;

  spi_ee_slave #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
    .so_o(so_o), .so_oe_o(so_oe_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_rdata_i(mem_rdata_i),
    .lock_code_o(lock_code_o), .guard_block_i(guard_block_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 7 + 3) ^ (i >> 3));
  endfunction

  // guard model: code k locks the top k eighths of the array
  function automatic logic guarded(logic [2:0] k, logic [8:0] a);
    return (k != 3'd0) && (int'(a[8:6]) >= 8 - int'(k));
  endfunction

  assign mem_rdata_i   = mem[mem_addr_o];
  assign guard_block_i = guarded(lock_code_o, mem_addr_o);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= init_val(i);
    end else if (mem_we_o) begin
      mem[mem_addr_o] <= mem_wdata_o;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      si = tx[i];
      tick(HALF);
      rx[i] = so_o;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic cs_off();
    tick(2);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic op1(input logic [7:0] code);
    logic [7:0] r;
    cs_on(); xfer(code, 8, r); cs_off();
    if (code == 8'h06) exp_wel = 1'b1;
    if (code == 8'h04) exp_wel = 1'b0;
  endtask

  task automatic send_write(input logic [15:0] a, input int n, input int cut);
    logic [7:0] r;
    cs_on();
    xfer(8'h02, 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
    for (int i = 0; i < n; i++) xfer(wbytes[i], 8, r);
    if (cut > 0) xfer(8'hA5, cut, r);
    cs_off();
  endtask

  task automatic model_write(input logic [15:0] a, input int n, input int cut);
    logic [8:0] ad;
    if (exp_wel && cut == 0 && n > 0) begin
      for (int i = 0; i < n; i++) begin
        ad = {a[8:4], 4'(int'(a[3:0]) + i)};
        if (!guarded(exp_lock, ad)) exp_mem[ad] = wbytes[i];
      end
      exp_wel = 1'b0;
    end
  endtask

  task automatic wait_idle();
    tick(BUSY + 80);
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input int cut);
    send_write(a, n, cut);
    model_write(a, n, cut);
    wait_idle();
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string req);
    logic [7:0] r;
    cs_on();
    xfer(8'h03, 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, r);
      chk(req, r, exp_mem[9'(int'(a[8:0]) + i)]);
    end
    cs_off();
  endtask

  task automatic rdsr1(output logic [7:0] r);
    logic [7:0] t;
    cs_on(); xfer(8'h05, 8, t); xfer(8'h00, 8, r); cs_off();
  endtask

  initial begin
    tick(190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] r;
    logic [7:0] st;
    logic [15:0] ra;
    int rn, rcut;
    bit ok;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0;
    exp_wel = 1'b0; exp_lock = 3'd0;
    for (int i = 0; i < 512; i++) exp_mem[i] = init_val(i);
    void'($urandom(32'd12345));
    tick(6);
    // R1 reset state
    chk("R1 oe", so_oe_o, 0);
    chk("R1 we", mem_we_o, 0);
    chk("R1 lock", lock_code_o, 0);
    rst_n = 1'b1;
    tick(6);

    // R1: no enable after reset, write ignored
    for (int i = 0; i < 3; i++) wbytes[i] = 8'h90 + 8'(i);
    do_write(16'h0010, 3, 0);
    do_read(16'h0010, 3, "R1");

    // R2 enable follows select; R4 upper address bits ignored
    op1(8'h06);
    for (int i = 0; i < 4; i++) wbytes[i] = 8'h3C + 8'(i * 17);
    cs_on();
    chk("R2 oe low sel", so_oe_o, 1);
    cs_off();
    chk("R2 oe high sel", so_oe_o, 0);
    do_write(16'hA123, 4, 0);
    do_read(16'h0123, 4, "R4");

    // R8: latch cleared after commit
    for (int i = 0; i < 2; i++) wbytes[i] = 8'hE0 + 8'(i);
    do_write(16'h0123, 2, 0);
    do_read(16'h0123, 2, "R8 latch cleared");

    // R8: enable followed by more bits in same select does not count
    cs_on(); xfer(8'h06, 8, r); xfer(8'h02, 8, r); xfer(8'h00, 8, r);
    xfer(8'h30, 8, r); xfer(8'h77, 8, r); cs_off();
    do_write(16'h0030, 2, 0);
    do_read(16'h0030, 2, "R8 enable run-on");

    // R3 clear-enable command
    op1(8'h06); op1(8'h04);
    do_write(16'h0034, 2, 0);
    do_read(16'h0034, 2, "R3 clear enable");

    // R6 page wrap with overwrite
    op1(8'h06);
    for (int i = 0; i < 18; i++) wbytes[i] = 8'(8'h11 * i + 8'h05);
    do_write(16'h00AE, 18, 0);
    do_read(16'h00A0, 16, "R6");

    // R7 abort mid-byte, then latch still set
    op1(8'h06);
    for (int i = 0; i < 2; i++) wbytes[i] = 8'h5A ^ 8'(i);
    do_write(16'h0040, 2, 3);
    do_read(16'h0040, 2, "R7 abort");
    do_write(16'h0048, 0, 0);
    wbytes[0] = 8'hC7;
    do_write(16'h0041, 1, 0);
    do_read(16'h0040, 2, "R7 latch kept");

    // R5 read wrap across the top of the array
    do_read(16'h01FE, 5, "R5");

    // R11 lock without enable ignored, then with enable
    cs_on(); xfer(8'h01, 8, r); xfer(8'h03, 8, r); cs_off();
    wait_idle();
    chk("R11 lock needs enable", lock_code_o, 0);
    op1(8'h06);
    cs_on(); xfer(8'h01, 8, r); xfer(8'hFB, 8, r); cs_off();
    exp_lock = 3'd3; exp_wel = 1'b0;
    wait_idle();
    chk("R11 lock code", lock_code_o, 3);
    rdsr1(r);
    chk("R9 status", r, 8'h03);
    do_write(16'h0020, 1, 0);
    do_read(16'h0020, 1, "R8 after lock");
    op1(8'h06);
    for (int i = 0; i < 4; i++) wbytes[i] = 8'hA0 + 8'(i);
    do_write(16'h0150, 4, 0);
    do_read(16'h0150, 4, "R11 guarded");

    // R9 status during busy: ones, then status with aligned pointer
    op1(8'h06);
    wbytes[0] = 8'h6B;
    send_write(16'h0022, 1, 0);
    model_write(16'h0022, 1, 0);
    st = 8'h03;
    cs_on(); xfer(8'h05, 8, r);
    for (int i = 0; i < 20; i++) begin
      xfer(8'h00, 8, r);
      if (i == 0) chk("R9 busy ones", r, 8'hFF);
      if (i == 19) chk("R9 status after busy", r, st);
      ok = 1'b0;
      for (int k = 0; k <= 8; k++) if (r == (st | ~(8'hFF >> k))) ok = 1'b1;
      chk("R9 pointer alignment", ok, 1);
    end
    cs_off();
    wait_idle();
    do_read(16'h0022, 1, "R9 data");

    // R10 busy window and ignored commands
    op1(8'h06);
    for (int i = 0; i < 2; i++) wbytes[i] = 8'h2D + 8'(i);
    send_write(16'h0060, 2, 0);
    model_write(16'h0060, 2, 0);
    cs_on(); xfer(8'h03, 8, r); xfer(8'h00, 8, r); xfer(8'h00, 8, r);
    xfer(8'h00, 8, r); cs_off();
    chk("R10 read ignored", r, 8'h00);
    cs_on(); xfer(8'h02, 8, r); xfer(8'h00, 8, r); xfer(8'h70, 8, r);
    xfer(8'h99, 8, r); cs_off();
    rdsr1(r);
    chk("R10 still busy", r, 8'hFF);
    tick(BUSY);
    rdsr1(r);
    chk("R10 busy ended", r, 8'h03);
    do_read(16'h0060, 2, "R10 commit");
    do_read(16'h0070, 1, "R10 write ignored");

    // random writes mixed with the directed cases
    for (int it = 0; it < 10; it++) begin
      ra   = 16'($urandom);
      rn   = 1 + int'($urandom % 20);
      rcut = ($urandom % 7 == 0) ? 1 + int'($urandom % 7) : 0;
      if ($urandom % 4 != 0) op1(8'h06);
      for (int i = 0; i < rn; i++) wbytes[i] = 8'($urandom);
      do_write(ra, rn, rcut);
      do_read({7'h00, ra[8:4], 4'h0}, 16, "R6 R7 random");
    end

    finish_up();
  end

endmodule